// File: doc/BRIEF.md
# Priority-Programmable Interrupt Controller

This block merges thirteen level-sensitive request lines, numbered 1 to 13, into one prioritised request to a processor. Each source has an 8-bit control word. The low five bits of that word are the source's priority. Bits [4:2] of the same word are the level presented to the processor, and bit 7 selects an automatic vector. A 16-bit mask word blocks sources: a mask bit of 1 blocks its source. A pending word follows the request lines.

On every clock the block picks the unmasked pending source with the greatest priority value. On equal priority values it keeps the lower-numbered source. It then drives a registered 3-bit level and an 8-bit vector. The vector is either 24 plus the level, or a fixed byte supplied per source on an input bus. In a typical system the two timers use sources 9 and 10, and the two serial ports use sources 12 and 13. Software writes the mask and control words through a single-cycle write port.

Top module: `prio_intc`

## Requirements
- R1: The pending bit of source i (bit i of `src_i`, i = 1..13) is captured on every clock edge. It is set while the line is high and cleared while it is low.
- R2: A source whose mask bit (bit i of the mask word) is 1 never wins selection.
- R3: The priority of source i is bits [4:2..0], that is the low five bits, of its control word. The active source with the strictly greatest priority wins.
- R4: When two active sources have equal priority, the lower-numbered source wins.
- R5: `irq_level_o` equals bits [4:2] of the winning source's control word.
- R6: When no source is active, or every active source has priority 0, both `irq_level_o` and `irq_vector_o` are 0.
- R7: When bit 7 of the winner's control word is 1, `irq_vector_o` equals 24 plus the level.
- R8: When bit 7 of the winner's control word is 0, `irq_vector_o` equals byte i of `vec_i`, which is bits [8*(i-1)+7 : 8*(i-1)].
- R9: A clock edge with `rst_n` low does three things. It sets the mask word to 0x3FFE, so sources 1 to 13 are all masked. It clears every control word and the pending word. It drives both outputs to 0.
- R10: A cycle with `cfg_we` = 1 and `cfg_is_mask` = 1 loads `cfg_wdata` into the mask word. A cycle with `cfg_we` = 1 and `cfg_is_mask` = 0 loads `cfg_wdata[7:0]` into the control word selected by `cfg_idx`. Values of `cfg_idx` of 0, 14 or 15 change nothing.
- R11: The outputs are registered. They reflect the pending, mask and control words as they stood after the previous clock edge. A change on `src_i` or a write therefore shows at the outputs after the second clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 13 ([13:1]) | Request lines, bit i is source i |
| vec_i | input | 104 | Fixed vector bytes, byte i-1 belongs to source i |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_mask | input | 1 | 1: write mask word, 0: write control word |
| cfg_idx | input | 4 | Source number for control writes |
| cfg_wdata | input | 16 | Write data |
| irq_level_o | output | 3 | Level presented to the processor, 0 = none |
| irq_vector_o | output | 8 | Vector of the winning source, 0 = none |

## Verification
Every result of this block is due two clock edges after its stimulus. The first edge captures a request line or a write into the pending, mask or control word. The second edge turns the words into the registered level and vector. The bench keeps its reference state one edge behind the inputs. At each falling edge it compares the outputs with the prediction made at the previous falling edge. It then forms a new prediction from the model state and only afterwards applies the inputs that the next rising edge will capture. Inputs change only just after a rising edge, so the vector bytes used in a prediction are the ones the design sees at that rising edge.

// File: rtl/ipc_pkg.sv
// Package ipc_pkg
// Purpose: shared widths, constants and the selection result type of the
// priority interrupt controller.
// Assumes: control words are 8 bits with priority in [4:0] and level in [4:2].
package ipc_pkg;
    localparam int CTRL_W    = 8;
    localparam int PRI_W     = 5;
    localparam int LVL_W     = 3;
    localparam int LVL_LSB   = 2;
    localparam int VEC_W     = 8;
    localparam int AUTO_BIT  = 7;
    localparam int AUTO_BASE = 24;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic             auto_vec;
    } sel_t;
endpackage

// File: rtl/ipc_regs.sv
// Module ipc_regs
// Purpose: holds the pending, mask and per-source control words.
// Assumes: one write per cycle; control writes to numbers outside 1..NUM_SRC
// are dropped; synchronous active-low reset.
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int NUM_SRC    = 13,
    parameter int MASK_W     = 16,
    parameter int IDX_W      = 4,
    parameter logic [MASK_W-1:0] RESET_MASK = 16'h3FFE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC:1]              src_i,
    input  logic                          cfg_we,
    input  logic                          cfg_is_mask,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [MASK_W-1:0]             cfg_wdata,
    output logic [NUM_SRC:1]              pend_o,
    output logic [MASK_W-1:0]             mask_o,
    output logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_o
);

    // Capture the live request levels once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= src_i;
    end

    // Mask word: loaded whole by a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mask_o <= RESET_MASK;
        else if (cfg_we && cfg_is_mask) mask_o <= cfg_wdata;
    end

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_ctrl
        // Control word of source g: loaded by a control write addressed to g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_o[g] <= '0;
            else if (cfg_we && !cfg_is_mask && (cfg_idx == IDX_W'(g)))
                ctrl_o[g] <= cfg_wdata[CTRL_W-1:0];
        end
    end

    AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o == $past(src_i)));                                // R1
    AST_RESET_MASK: assert property (@(posedge clk)
        !rst_n |=> (mask_o == RESET_MASK));                                // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_is_mask) |=> $stable(mask_o));                     // R10
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ctrl_o));                                      // R10

endmodule

// File: rtl/ipc_select.sv
// Module ipc_select
// Purpose: picks the active source with the strictly greatest priority,
// keeping the lowest number on ties, and reports its level and vector mode.
// Assumes: purely combinational; clk and rst_n feed only the assertions.
module ipc_select
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int MASK_W  = 16,
    parameter int IDX_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC:1]              pend_i,
    input  logic [MASK_W-1:0]             mask_i,
    input  logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_i,
    output logic [IDX_W-1:0]              win_idx_o,
    output sel_t                          win_o
);

    logic [NUM_SRC:1] active;
    logic [PRI_W-1:0] best_pri;

    // Unmasked pending sources.
    always_comb active = pend_i & ~mask_i[NUM_SRC:1];

    // Ascending scan with strict compare keeps the lowest number on ties.
    always_comb begin
        best_pri  = '0;
        win_idx_o = '0;
        win_o     = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && (ctrl_i[i][PRI_W-1:0] > best_pri)) begin
                best_pri       = ctrl_i[i][PRI_W-1:0];
                win_idx_o      = IDX_W'(i);
                win_o.valid    = 1'b1;
                win_o.level    = ctrl_i[i][LVL_LSB +: LVL_W];
                win_o.auto_vec = ctrl_i[i][AUTO_BIT];
            end
        end
    end

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        win_o.valid |-> !mask_i[win_idx_o]);                               // R2
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        win_o.valid |-> pend_i[win_idx_o]);                                // R3
    AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> !win_o.valid);                                  // R6

endmodule

// File: rtl/ipc_vecout.sv
// Module ipc_vecout
// Purpose: registers the level and forms the vector, either automatic
// (AUTO_BASE plus level) or the winner's fixed byte.
// Assumes: an invalid selection drives level and vector to 0.
module ipc_vecout
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  sel_t                         win_i,
    input  logic [IDX_W-1:0]             win_idx_i,
    input  logic [NUM_SRC:1][VEC_W-1:0]  vec_i,
    output logic [LVL_W-1:0]             level_o,
    output logic [VEC_W-1:0]             vector_o
);

    logic [VEC_W-1:0] fixed_vec;
    logic [VEC_W-1:0] next_vec;

    // Fixed vector byte of the current winner.
    always_comb begin
        fixed_vec = '0;
        for (int i = 1; i <= NUM_SRC; i++)
            if (win_idx_i == IDX_W'(i)) fixed_vec = vec_i[i];
    end

    // Vector source choice.
    always_comb begin
        if (!win_i.valid)       next_vec = '0;
        else if (win_i.auto_vec) next_vec = VEC_W'(AUTO_BASE) + VEC_W'(win_i.level);
        else                    next_vec = fixed_vec;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o  <= '0;
            vector_o <= '0;
        end else begin
            level_o  <= win_i.valid ? win_i.level : '0;
            vector_o <= next_vec;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i.valid |=> (level_o == '0 && vector_o == '0));               // R6
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        win_i.valid |=> (level_o == $past(win_i.level)));                  // R5
    AST_AUTO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i.valid && win_i.auto_vec) |=>
            (vector_o == VEC_W'(AUTO_BASE) + VEC_W'(level_o)));            // R7
    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |=> (level_o == '0 && vector_o == '0));                     // R9

endmodule

// File: rtl/prio_intc.sv
// Module prio_intc
// Purpose: top of the priority interrupt controller; register bank,
// selector and registered output stage.
// Assumes: NUM_SRC <= 15 so a source number fits IDX_W bits; MASK_W > NUM_SRC.
module prio_intc
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int MASK_W  = 16,
    parameter logic [MASK_W-1:0] RESET_MASK = 16'h3FFE,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC:1]         src_i,
    input  logic [NUM_SRC*VEC_W-1:0] vec_i,
    input  logic                     cfg_we,
    input  logic                     cfg_is_mask,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [MASK_W-1:0]        cfg_wdata,
    output logic [LVL_W-1:0]         irq_level_o,
    output logic [VEC_W-1:0]         irq_vector_o
);

    logic [NUM_SRC:1]              pend;
    logic [MASK_W-1:0]             mask;
    logic [NUM_SRC:1][CTRL_W-1:0]  ctrl;
    logic [NUM_SRC:1][VEC_W-1:0]   vec_arr;
    logic [IDX_W-1:0]              win_idx;
    sel_t                          win;

    // Reshape the flat vector bus so that byte i-1 belongs to source i.
    always_comb vec_arr = vec_i;

    ipc_regs #(
        .NUM_SRC(NUM_SRC), .MASK_W(MASK_W), .IDX_W(IDX_W), .RESET_MASK(RESET_MASK)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata),
        .pend_o(pend), .mask_o(mask), .ctrl_o(ctrl)
    );

    ipc_select #(
        .NUM_SRC(NUM_SRC), .MASK_W(MASK_W), .IDX_W(IDX_W)
    ) sel_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .ctrl_i(ctrl),
        .win_idx_o(win_idx), .win_o(win)
    );

    ipc_vecout #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
    ) out_i (
        .clk(clk), .rst_n(rst_n), .win_i(win), .win_idx_i(win_idx),
        .vec_i(vec_arr), .level_o(irq_level_o), .vector_o(irq_vector_o)
    );

endmodule

// File: tb/prio_intc_tb.sv
// Bench for prio_intc: a behavioural model one edge behind the inputs,
// compared with the outputs at every falling edge.
module prio_intc_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:1]  src_i = '0;
    logic [103:0] vec_i = '0;
    logic         cfg_we = 1'b0;
    logic         cfg_is_mask = 1'b0;
    logic [3:0]   cfg_idx = '0;
    logic [15:0]  cfg_wdata = '0;
    logic [2:0]   irq_level_o;
    logic [7:0]   irq_vector_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_req = "R9";

    int m_pend[14];
    int m_mask;
    int m_ctrl[14];
    int exp_lvl = 0;
    int exp_vec = 0;

    always #5 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .vec_i(vec_i),
        .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .irq_level_o(irq_level_o), .irq_vector_o(irq_vector_o)
    );

    // Reference selection: greatest priority, ties kept by the lower number.
    task automatic predict(output int lvl, output int vec);
        int best = 0;
        int win = 0;
        for (int i = 1; i <= 13; i++) begin
            if (m_pend[i] != 0 && ((m_mask >> i) & 1) == 0 && (m_ctrl[i] & 31) > best) begin
                best = m_ctrl[i] & 31;
                win = i;
            end
        end
        if (win == 0) begin
            lvl = 0; vec = 0;
        end else begin
            lvl = (m_ctrl[win] >> 2) & 7;
            vec = ((m_ctrl[win] >> 7) & 1) != 0 ? 24 + lvl : int'(vec_i[8*(win-1) +: 8]);
        end
    endtask

    task automatic check(string req, int act, int expv, string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
        end
    endtask

    // Per-cycle comparison and model update (R11 latency lives here).
    always @(negedge clk) begin
        int nl, nv;
        if (!rst_n) begin
            m_mask = 16'h3FFE;
            for (int i = 0; i < 14; i++) begin m_pend[i] = 0; m_ctrl[i] = 0; end
            exp_lvl = 0; exp_vec = 0;
            armed = 1;
        end else if (armed) begin
            check(cur_req, int'(irq_level_o), exp_lvl, "level");
            check(cur_req, int'(irq_vector_o), exp_vec, "vector");
            predict(nl, nv);
            exp_lvl = nl; exp_vec = nv;
            for (int i = 1; i <= 13; i++) m_pend[i] = int'(src_i[i]);
            if (cfg_we) begin
                if (cfg_is_mask) m_mask = int'(cfg_wdata);
                else if (cfg_idx >= 1 && cfg_idx <= 13) m_ctrl[cfg_idx] = int'(cfg_wdata[7:0]);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(bit is_mask, int idx, int data);
        cfg_we = 1'b1; cfg_is_mask = is_mask; cfg_idx = 4'(idx); cfg_wdata = 16'(data);
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 1; i <= 13; i++) vec_i[8*(i-1) +: 8] = 8'(8'h40 + i);
        step(3);
        rst_n = 1'b1;
        // R9: all lines high but every source masked after reset.
        cur_req = "R9";
        src_i = '1;
        step(4);
        check("R9", int'(irq_level_o), 0, "reset level");
        check("R9", int'(irq_vector_o), 0, "reset vector");
        // R10: control writes, including ignored numbers 0, 14, 15.
        cur_req = "R10";
        wr(0, 3, 'h0C);   wr(0, 5, 'h0C);   wr(0, 9, 'h95);
        wr(0, 12, 'h1F);  wr(0, 7, 'h00);   wr(0, 0, 'hFF);
        wr(0, 14, 'hFF);  wr(0, 15, 'hFF);
        src_i = '0;
        wr(1, 0, 'h0000);
        step(2);
        check("R10", int'(irq_level_o), 0, "no lines, level");
        // R3/R5/R7: source 9 (pri 21, auto) beats 3.
        cur_req = "R7";
        src_i = 13'b0_0001_0000_0100;
        step(3);
        check("R7", int'(irq_vector_o), 24 + 5, "auto vector");
        // R3: source 12 (pri 31) wins, fixed vector R8.
        cur_req = "R8";
        src_i[12] = 1'b1;
        step(3);
        check("R8", int'(irq_vector_o), 'h4C, "fixed vector");
        check("R5", int'(irq_level_o), 7, "level of 12");
        // R4: tie between 3 and 5.
        cur_req = "R4";
        src_i = '0; src_i[5] = 1'b1; src_i[3] = 1'b1;
        step(3);
        check("R4", int'(irq_vector_o), 'h43, "tie winner");
        // R2: mask source 3, 5 takes over.
        cur_req = "R2";
        wr(1, 0, 'h0008);
        step(2);
        check("R2", int'(irq_vector_o), 'h45, "masked 3");
        // R6: only a priority-0 source is active.
        cur_req = "R6";
        src_i = '0; src_i[7] = 1'b1;
        step(3);
        check("R6", int'(irq_level_o), 0, "pri zero level");
        // R1/R11: random lines, writes and vector bytes.
        cur_req = "R1";
        for (int k = 0; k < 600; k++) begin
            src_i = 13'($urandom);
            if (k % 50 == 25) vec_i[8*($urandom % 13) +: 8] = 8'($urandom);
            if ($urandom % 4 == 0) begin
                cur_req = "R11";
                wr($urandom % 5 == 0, $urandom % 16, $urandom);
            end else begin
                step(1);
            end
        end
        step(3);
        finish_run();
    end
endmodule